// File: doc/BRIEF.md
# Serial Port FIFO Pair with Fill-Level Status

This block holds the two data queues of an asynchronous serial controller. Bus software pushes bytes into a transmit queue that the serial shifter drains. The receive shifter fills a second queue that software drains. Each queue has a small control word with an enable, a self-clearing flush and a trigger level. Both fill levels are packed into one status word.

Three interrupt requests are latched in a node register and cleared by writing ones to it. The transmit request fires when the transmit queue drains down to its trigger level. The receive request fires when the receive queue fills up to its trigger level. The error request fires on an external error event or on a receive overrun. Here the shift engines appear only as push and pop strobes.

Top module: `uart_fifo_pair`

## Requirements
- R1: `cfg_addr` selects the target of a `cfg_wr` write: 0 is transmit control, 1 is receive control, 2 is the interrupt node. In a control word, bit 0 enables the queue, bit 1 requests a flush and bits 13:8 hold the 6-bit trigger level.
- R2: `fifo_stat` carries the transmit fill level in bits 13:8 and the receive fill level in bits 5:0. All other bits read zero.
- R3: Each queue returns bytes in push order and holds 16 entries. A level of 16 means full, and a push into a full transmit queue is dropped. `tx_rdata` and `rx_rdata` show the oldest entry. `tx_empty` is high only when the transmit level is zero.
- R4: A flush bit is not stored. In the cycle after the write, it empties the queue and zeroes its pointers and level. Pushes and pops are ignored in that cycle.
- R5: While a queue is disabled, its level reads zero, its read data reads zero and its push strobes are ignored.
- R6: A receive push while the receive queue is full is dropped. One cycle later, `rx_overrun` pulses high for exactly one cycle, and that pulse sets the error request.
- R7: A pop from an empty queue leaves the level unchanged, and the read data shows zero.
- R8: Interrupt bit 1 (receive) is set when the receive queue is enabled and its level moves from below the trigger level to at or above it.
- R9: Interrupt bit 0 (transmit) is set when the transmit queue is enabled and its level moves from above the trigger level to at or below it. Enabling the queue while its level is already at or below the trigger also sets the bit.
- R10: Interrupt bit 2 (error) is set in the cycle after `err_in` is high.
- R11: Writing ones to the interrupt node clears the matching pending bits. If a bit is set and cleared in the same cycle, the set wins.
- R12: After reset, both queues are disabled, every level and pending bit is zero, and `tx_empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (0 transmit control, 1 receive control, 2 interrupt node) |
| cfg_wdata | input | 14 | Register write data |
| tx_push | input | 1 | Bus push into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Transmit shifter takes the oldest byte |
| tx_rdata | output | 8 | Oldest transmit byte, zero when empty or disabled |
| tx_empty | output | 1 | Transmit level is zero |
| rx_push | input | 1 | Receive shifter pushes a byte |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Bus pop from the receive queue |
| rx_rdata | output | 8 | Oldest receive byte, zero when empty or disabled |
| rx_overrun | output | 1 | One-cycle pulse after a receive push was dropped as full |
| err_in | input | 1 | Line error event from the receiver |
| fifo_stat | output | 16 | Packed fill levels of both queues |
| irq_pend | output | 3 | Pending requests: bit 0 transmit, bit 1 receive, bit 2 error |

## Verification
The bench builds the block with the default parameters: depth 16 in each direction, 8-bit data and a 6-bit level field. With these values the full boundary is reached after a few dozen strobes. That makes the seventeenth transmit push, the receive overrun and its error request, and the in-order drain after the drop all directly observable. The trigger levels of 2 and 3 sit low enough that both threshold crossings can be observed in both directions within one short vector table.

// File: rtl/ufq_pkg.sv
package ufq_pkg;
   typedef enum logic [1:0] {
      SEL_TXCTL = 2'd0,
      SEL_RXCTL = 2'd1,
      SEL_IRQ   = 2'd2,
      SEL_NONE  = 2'd3
   } ufq_sel_e;

   localparam int EN_BIT    = 0;
   localparam int FLUSH_BIT = 1;
   localparam int TRIG_LSB  = 8;

   localparam int IRQ_TX  = 0;
   localparam int IRQ_RX  = 1;
   localparam int IRQ_ERR = 2;
   localparam int IRQ_N   = 3;
endpackage

// File: rtl/ufq_chan.sv
module ufq_chan #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   parameter int LVL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             ctl_en,
   input  logic             ctl_flush,
   input  logic [LVL_W-1:0] ctl_trig,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop,
   output logic             en,
   output logic [LVL_W-1:0] trig,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic [DW-1:0]    rdata
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0 || DEPTH >= (1 << LVL_W)) begin : g_bad_depth
      $error("ufq_chan: DEPTH must be a power of two, at least 2, below 2**LVL_W");
   end

   logic             en_q;
   logic             flush_q;
   logic [LVL_W-1:0] trig_q;
   logic [AW-1:0]    wp_q;
   logic [AW-1:0]    rp_q;
   logic [CW-1:0]    cnt_q;
   logic [DW-1:0]    rows [DEPTH];

   logic is_full, is_empty, push_ok, pop_ok;

   assign is_full  = (cnt_q == CW'(DEPTH));
   assign is_empty = (cnt_q == '0);
   assign push_ok  = en_q && push && !flush_q && !is_full;
   assign pop_ok   = en_q && pop  && !flush_q && !is_empty;

   // control word: flush is a one-cycle request, never stored beyond that
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         flush_q <= 1'b0;
         trig_q  <= '0;
      end else if (ctl_wr) begin
         en_q    <= ctl_en;
         flush_q <= ctl_flush;
         trig_q  <= ctl_trig;
      end else begin
         flush_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else if (flush_q) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + AW'(1);
         if (pop_ok)  rp_q <= rp_q + AW'(1);
         unique case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
      logic [DW-1:0] row_q;
      always_ff @(posedge clk) begin
         if (push_ok && wp_q == AW'(gi)) row_q <= push_data;
      end
      assign rows[gi] = row_q;
   end

   assign en    = en_q;
   assign trig  = trig_q;
   assign level = en_q ? LVL_W'(cnt_q) : '0;
   assign full  = en_q && is_full;
   assign rdata = (en_q && !is_empty) ? rows[rp_q] : '0;
endmodule

// File: rtl/ufq_irq_node.sv
module ufq_irq_node #(
   parameter int NREQ = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-2:0] lvl_cond,
   input  logic            evt,
   input  logic            clr_wr,
   input  logic [NREQ-1:0] clr_mask,
   output logic [NREQ-1:0] pend
);
   localparam int NLVL = NREQ - 1;

   if (NREQ < 2) begin : g_bad_nreq
      $error("ufq_irq_node: NREQ must be at least 2");
   end

   logic [NREQ-1:0] set_vec;
   logic [NREQ-1:0] clr_vec;
   logic [NREQ-1:0] pend_q;

   // level conditions become requests only on their rising transition
   for (genvar gi = 0; gi < NLVL; gi++) begin : g_edge
      logic cond_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cond_q <= 1'b0;
         else        cond_q <= lvl_cond[gi];
      end
      assign set_vec[gi] = lvl_cond[gi] && !cond_q;
   end
   assign set_vec[NREQ-1] = evt;

   assign clr_vec = clr_wr ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end

   assign pend = pend_q;
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
   import ufq_pkg::*;
#(
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16,
   parameter int DW       = 8,
   parameter int LVL_W    = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_wr,
   input  logic [1:0]                cfg_addr,
   input  logic [TRIG_LSB+LVL_W-1:0] cfg_wdata,
   input  logic                      tx_push,
   input  logic [DW-1:0]             tx_wdata,
   input  logic                      tx_pop,
   output logic [DW-1:0]             tx_rdata,
   output logic                      tx_empty,
   input  logic                      rx_push,
   input  logic [DW-1:0]             rx_wdata,
   input  logic                      rx_pop,
   output logic [DW-1:0]             rx_rdata,
   output logic                      rx_overrun,
   input  logic                      err_in,
   output logic [2*LVL_W+3:0]        fifo_stat,
   output logic [IRQ_N-1:0]          irq_pend
);
   localparam int TRIG_MSB = TRIG_LSB + LVL_W - 1;

   if (LVL_W + 2 != TRIG_LSB) begin : g_bad_lvl
      $error("uart_fifo_pair: status packing expects LVL_W + 2 == TRIG_LSB");
   end

   logic             tx_ctl_wr, rx_ctl_wr, irq_wr;
   logic             tx_en, rx_en, tx_full, rx_full;
   logic [LVL_W-1:0] tx_trig, rx_trig, tx_lvl, rx_lvl;
   logic             rx_ovr_q;
   logic [IRQ_N-2:0] lvl_cond;

   assign tx_ctl_wr = cfg_wr && (cfg_addr == SEL_TXCTL);
   assign rx_ctl_wr = cfg_wr && (cfg_addr == SEL_RXCTL);
   assign irq_wr    = cfg_wr && (cfg_addr == SEL_IRQ);

   ufq_chan #(.DEPTH(TX_DEPTH), .DW(DW), .LVL_W(LVL_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (tx_ctl_wr),
      .ctl_en    (cfg_wdata[EN_BIT]),
      .ctl_flush (cfg_wdata[FLUSH_BIT]),
      .ctl_trig  (cfg_wdata[TRIG_MSB:TRIG_LSB]),
      .push      (tx_push),
      .push_data (tx_wdata),
      .pop       (tx_pop),
      .en        (tx_en),
      .trig      (tx_trig),
      .level     (tx_lvl),
      .full      (tx_full),
      .rdata     (tx_rdata)
   );

   ufq_chan #(.DEPTH(RX_DEPTH), .DW(DW), .LVL_W(LVL_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (rx_ctl_wr),
      .ctl_en    (cfg_wdata[EN_BIT]),
      .ctl_flush (cfg_wdata[FLUSH_BIT]),
      .ctl_trig  (cfg_wdata[TRIG_MSB:TRIG_LSB]),
      .push      (rx_push),
      .push_data (rx_wdata),
      .pop       (rx_pop),
      .en        (rx_en),
      .trig      (rx_trig),
      .level     (rx_lvl),
      .full      (rx_full),
      .rdata     (rx_rdata)
   );

   // dropped receive byte: registered one-cycle pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_ovr_q <= 1'b0;
      else        rx_ovr_q <= rx_push && rx_full;
   end

   assign lvl_cond[IRQ_TX] = tx_en && (tx_lvl <= tx_trig);
   assign lvl_cond[IRQ_RX] = rx_en && (rx_lvl >= rx_trig);

   ufq_irq_node #(.NREQ(IRQ_N)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_cond (lvl_cond),
      .evt      (err_in || rx_ovr_q),
      .clr_wr   (irq_wr),
      .clr_mask (cfg_wdata[IRQ_N-1:0]),
      .pend     (irq_pend)
   );

   assign rx_overrun = rx_ovr_q;
   assign tx_empty   = (tx_lvl == '0);
   assign fifo_stat  = {2'b00, tx_lvl, 2'b00, rx_lvl};

   logic unused_tx_full;
   assign unused_tx_full = tx_full;
endmodule

// File: rtl/ufq_chk.sv
module ufq_chk #(
   parameter int TX_DEPTH = 16,
   parameter int RX_DEPTH = 16,
   parameter int LVL_W    = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_wr,
   input logic [1:0]           cfg_addr,
   input logic [LVL_W+7:0]     cfg_wdata,
   input logic                 rx_push,
   input logic                 rx_pop,
   input logic [7:0]           rx_rdata,
   input logic                 rx_overrun,
   input logic                 err_in,
   input logic [2*LVL_W+3:0]   fifo_stat,
   input logic [2:0]           irq_pend
);
   logic [LVL_W-1:0] tx_lvl, rx_lvl;
   assign tx_lvl = fifo_stat[2*LVL_W+1:LVL_W+2];
   assign rx_lvl = fifo_stat[LVL_W-1:0];

   // R3
   tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_lvl <= LVL_W'(TX_DEPTH));

   // R3
   rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_lvl <= LVL_W'(RX_DEPTH));

   // R4
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 2'd0 && cfg_wdata[1]) |=> ##1 (tx_lvl == '0));

   // R5
   rx_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 2'd1 && !cfg_wdata[0]) |=> (rx_lvl == '0 && rx_rdata == '0));

   // R6
   rx_overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> ($past(rx_push) && $past(rx_lvl) == LVL_W'(RX_DEPTH)));

   // R7
   rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pop && !rx_push && !cfg_wr && rx_lvl == '0) |=> (rx_lvl == '0));

   // R10
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_in |=> irq_pend[2]);

   // R11
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 2'd2 && cfg_wdata[2] && !err_in && !rx_overrun) |=> !irq_pend[2]);
endmodule

bind uart_fifo_pair ufq_chk #(
   .TX_DEPTH (TX_DEPTH),
   .RX_DEPTH (RX_DEPTH),
   .LVL_W    (LVL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .rx_push    (rx_push),
   .rx_pop     (rx_pop),
   .rx_rdata   (rx_rdata),
   .rx_overrun (rx_overrun),
   .err_in     (err_in),
   .fifo_stat  (fifo_stat),
   .irq_pend   (irq_pend)
);

// File: tb/tb_uart_fifo_pair.sv
`timescale 1ns/1ps
module tb_uart_fifo_pair;
   localparam logic [2:0] OP_TXCTL = 3'd0, OP_RXCTL = 3'd1, OP_IRQ = 3'd2, OP_TXPUSH = 3'd3,
                          OP_TXPOP = 3'd4, OP_RXPUSH = 3'd5, OP_RXPOP = 3'd6, OP_ERR = 3'd7;

   typedef struct packed {
      logic [2:0]  op;
      logic [15:0] arg;
      logic [15:0] stat;
      logic [2:0]  pend;
      logic [7:0]  rd;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 20;
   localparam vec_t VEC [NVEC] = '{
      '{OP_TXCTL,  16'h0201, 16'h0000, 3'b001, 8'h00, 4'd9 },  // R9 enable tx, trig 2
      '{OP_RXCTL,  16'h0301, 16'h0000, 3'b001, 8'h00, 4'd1 },  // R1 enable rx, trig 3
      '{OP_IRQ,    16'h0001, 16'h0000, 3'b000, 8'h00, 4'd11},  // R11 clear tx request
      '{OP_TXPUSH, 16'h00A1, 16'h0100, 3'b000, 8'hA1, 4'd2 },  // R2 tx level 1
      '{OP_TXPUSH, 16'h00B2, 16'h0200, 3'b000, 8'hA1, 4'd3 },  // R3 oldest stays at head
      '{OP_TXPUSH, 16'h00C3, 16'h0300, 3'b000, 8'hA1, 4'd3 },  // R3
      '{OP_TXPOP,  16'h0000, 16'h0200, 3'b001, 8'hB2, 4'd9 },  // R9 drain to trigger
      '{OP_RXPUSH, 16'h0011, 16'h0201, 3'b001, 8'h11, 4'd2 },  // R2 rx level in low bits
      '{OP_RXPUSH, 16'h0022, 16'h0202, 3'b001, 8'h11, 4'd3 },  // R3
      '{OP_RXPUSH, 16'h0033, 16'h0203, 3'b011, 8'h11, 4'd8 },  // R8 rx reaches trigger
      '{OP_RXPOP,  16'h0000, 16'h0202, 3'b011, 8'h22, 4'd3 },  // R3 order
      '{OP_IRQ,    16'h0002, 16'h0202, 3'b001, 8'h22, 4'd11},  // R11 clear rx request only
      '{OP_ERR,    16'h0000, 16'h0202, 3'b101, 8'h22, 4'd10},  // R10 error request
      '{OP_IRQ,    16'h0005, 16'h0202, 3'b000, 8'h22, 4'd11},  // R11 clear two bits
      '{OP_TXCTL,  16'h0203, 16'h0002, 3'b000, 8'h00, 4'd4 },  // R4 tx flush
      '{OP_RXCTL,  16'h0300, 16'h0000, 3'b000, 8'h00, 4'd5 },  // R5 rx disabled reads zero
      '{OP_RXPUSH, 16'h0044, 16'h0000, 3'b000, 8'h00, 4'd5 },  // R5 push ignored
      '{OP_RXCTL,  16'h0303, 16'h0000, 3'b000, 8'h00, 4'd4 },  // R4 enable with flush
      '{OP_RXPOP,  16'h0000, 16'h0000, 3'b000, 8'h00, 4'd7 },  // R7 pop on empty rx
      '{OP_TXPOP,  16'h0000, 16'h0000, 3'b000, 8'h00, 4'd7 }   // R7 pop on empty tx
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_addr = 2'd3;
   logic [13:0] cfg_wdata = '0;
   logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, err_in = 1'b0;
   logic [7:0]  tx_wdata = '0, rx_wdata = '0;
   logic [7:0]  tx_rdata, rx_rdata;
   logic        tx_empty, rx_overrun;
   logic [15:0] fifo_stat;
   logic [2:0]  irq_pend;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   uart_fifo_pair dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata), .tx_empty(tx_empty),
      .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_overrun(rx_overrun),
      .err_in(err_in), .fifo_stat(fifo_stat), .irq_pend(irq_pend)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [2:0] op, input logic [15:0] arg);
      case (op)
         OP_TXCTL:  begin cfg_wr = 1'b1; cfg_addr = 2'd0; cfg_wdata = arg[13:0]; end
         OP_RXCTL:  begin cfg_wr = 1'b1; cfg_addr = 2'd1; cfg_wdata = arg[13:0]; end
         OP_IRQ:    begin cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = arg[13:0]; end
         OP_TXPUSH: begin tx_push = 1'b1; tx_wdata = arg[7:0]; end
         OP_TXPOP:  tx_pop = 1'b1;
         OP_RXPUSH: begin rx_push = 1'b1; rx_wdata = arg[7:0]; end
         OP_RXPOP:  rx_pop = 1'b1;
         default:   err_in = 1'b1;
      endcase
   endtask

   task automatic idle_inputs();
      cfg_wr = 1'b0; cfg_addr = 2'd3; cfg_wdata = '0;
      tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; err_in = 1'b0;
   endtask

   // one strobe cycle, then settle
   task automatic apply(input logic [2:0] op, input logic [15:0] arg);
      @(negedge clk);
      drive(op, arg);
      @(negedge clk);
      idle_inputs();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 status", 32'(fifo_stat), 32'h0);
      check("R12 pending", 32'(irq_pend), 32'h0);
      check("R12 tx_empty", 32'(tx_empty), 32'h1);
      check("R12 overrun", 32'(rx_overrun), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [7:0] rd;
         apply(VEC[i].op, VEC[i].arg);
         rd = (VEC[i].op == OP_TXCTL || VEC[i].op == OP_TXPUSH || VEC[i].op == OP_TXPOP) ? tx_rdata : rx_rdata;
         check($sformatf("R%0d vector %0d", VEC[i].req, i),
               {5'd0, fifo_stat, irq_pend, rd}, {5'd0, VEC[i].stat, VEC[i].pend, VEC[i].rd});
      end

      // R3 fill transmit past capacity: the seventeenth push is dropped
      for (int i = 0; i < 17; i++) apply(OP_TXPUSH, 16'(8'h40 + i));
      check("R3 tx level at full", 32'(fifo_stat[13:8]), 32'd16);
      check("R3 tx head", 32'(tx_rdata), 32'h40);
      check("R3 tx_empty low", 32'(tx_empty), 32'h0);
      apply(OP_TXCTL, 16'h0203);
      check("R3 tx_empty after flush", 32'(tx_empty), 32'h1);

      // R6 receive overrun pulse timing and error request
      apply(OP_IRQ, 16'h0007);
      for (int i = 0; i < 16; i++) apply(OP_RXPUSH, 16'(i));
      check("R6 rx level at full", 32'(fifo_stat[5:0]), 32'd16);
      check("R6 no error yet", 32'(irq_pend[2]), 32'h0);
      @(negedge clk);
      rx_push = 1'b1; rx_wdata = 8'hEE;
      @(negedge clk);
      idle_inputs();
      check("R6 overrun pulse", 32'(rx_overrun), 32'h1);
      @(negedge clk);
      check("R6 overrun single cycle", 32'(rx_overrun), 32'h0);
      check("R6 error request", 32'(irq_pend[2]), 32'h1);
      check("R6 level unchanged", 32'(fifo_stat[5:0]), 32'd16);
      for (int i = 0; i < 15; i++) apply(OP_RXPOP, 16'h0);
      check("R6 dropped byte absent", 32'(rx_rdata), 32'h0F);

      // R11 set and clear of the error bit in the same cycle: set wins
      apply(OP_IRQ, 16'h0007);
      check("R11 cleared", 32'(irq_pend), 32'h0);
      @(negedge clk);
      err_in = 1'b1; cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = 14'h0004;
      @(negedge clk);
      idle_inputs();
      check("R11 set wins", 32'(irq_pend[2]), 32'h1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule